// File: doc/BRIEF.md
# Always-On Seconds Timer

This block is a free-running seconds counter meant for an always-powered region of a chip. A one-cycle slow tick, already aligned to the bus clock, feeds a programmable prescaler. Each time the prescaler completes a period, a 32-bit counter advances by one. Software cannot load the counter. It can only restart it from zero. Calendar conversion and any base-time offset are left to software.

The block has two sticky status flags. The alarm flag marks the step at which the counter moves past a programmed alarm value. The increment flag marks every counter step. Reading the status register returns both flags and clears them. A single level interrupt is raised while any flag is set and its enable bit is set. Each enable bit sits 16 bit positions above its flag.

The register bus is a simple synchronous word-addressed port. The address map is: 0 = mode, 1 = alarm, 2 = counter (read-only), 3 = status (read-only, clears on read). Read data is registered and appears on the cycle after the read strobe.

Top module: `rtt_seconds_timer`

## Requirements
- R1: The counter cannot be changed from the bus. A write to address 2 leaves the counter value unchanged.
- R2: Writing the mode register (address 0) with bit 18 set clears the counter and the prescaler phase to zero. Bit 18 always reads back as 0. Any increment due on that tick is dropped.
- R3: Mode bits [15:0] hold the division N. The counter steps once every N slow ticks. N = 0 means 65536 ticks.
- R4: A mode write that changes bits [15:0] restarts the prescaler phase from zero. A write with the same value keeps the phase.
- R5: The alarm register (address 1) resets to 0xFFFFFFFF. While it holds that value, no alarm event happens.
- R6: Status bit 0 (alarm) is set on the step in which the counter goes from the alarm value to the alarm value plus one.
- R7: Status bit 1 (increment) is set on every counter step.
- R8: A read of status (address 3) returns the flags as they were before the read, then clears both flags.
- R9: If a flag-setting event falls in the same cycle as a status read, that flag stays set after the read.
- R10: irq_o is high exactly when (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17) holds. Clearing an enable drops the interrupt but keeps the flag.
- R11: After reset, the registers read as follows: mode = default division with both enables clear, counter = 0, status = 0. irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow-clock tick, synchronous to clk_i |
| addr_i | input | 2 | Word address of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| irq_o | output | 1 | Level interrupt |

## Verification
Two things can land on the same clock edge: a status read that clears the flags, and a counter step that sets them. The bench forces this overlap with a directed case. It uses division 1, so every tick is a step, and issues a tick together with the status read. It then expects the read to return the old flags and a second read to show the new increment flag. Random traffic mixes ticks with status reads, alarm writes placed just ahead of the counter, and restarts. Every read value and the interrupt level on every cycle are compared against a bench model of the requirements.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int DATA_W  = 32;
  localparam int PRESC_W = 16;
  localparam int ADDR_W  = 2;

  localparam int MODE_ALM_EN  = 16;
  localparam int MODE_INC_EN  = 17;
  localparam int MODE_RESTART = 18;
  localparam int ST_ALM       = 0;
  localparam int ST_INC       = 1;
  localparam int EN_SHIFT     = MODE_ALM_EN - ST_ALM;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_ALARM  = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic               inc_en;
    logic               alm_en;
    logic [PRESC_W-1:0] div;
  } mode_t;
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int W = rtt_pkg::PRESC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  // div 0 -> last = all ones -> 2**W ticks
  assign last   = div_i - 1'b1;
  assign wrap_o = tick_i & ~restart_i & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  a_r4_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  a_r3_phase_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i && !wrap_o) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int W = rtt_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         inc_i,
  input  logic [W-1:0] alarm_i,
  output logic [W-1:0] cnt_o,
  output logic         alarm_hit_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step        = inc_i & ~restart_i;
  // all-ones alarm means disabled
  assign alarm_hit_o = step & (cnt_q == alarm_i) & ~(&alarm_i);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step)      cnt_q <= cnt_q + 1'b1;
  end

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !inc_i) |=> $stable(cnt_q));
  a_r2_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !restart_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r5_disabled_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alarm_i) |-> !alarm_hit_o);
endmodule

// File: rtl/rtt_status.sv
module rtt_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alm_ev_i,
  input  logic       inc_ev_i,
  input  logic       clr_i,
  input  logic [1:0] en_i,
  output logic [1:0] flags_o,
  output logic       irq_o
);
  logic [1:0] flag_q;
  logic [1:0] ev;

  assign ev = {inc_ev_i, alm_ev_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & {2{~clr_i}}) | ev;  // event beats clear
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);

  a_r9_event_survives_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_ev_i || inc_ev_i) |=> ((flag_q & $past(ev)) == $past(ev)));
  a_r8_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !alm_ev_i && !inc_ev_i) |=> flag_q == 2'b00);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $past(1'b1)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/rtt_seconds_timer.sv
module rtt_seconds_timer
  import rtt_pkg::*;
#(
  parameter logic [PRESC_W-1:0] RESET_DIV = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int MODE_USED = MODE_RESTART + 1;

  mode_t             mode_q;
  logic [DATA_W-1:0] alarm_q;
  logic [DATA_W-1:0] cnt;
  logic [1:0]        flags;
  logic              mode_wr, restart, div_chg, wrap, alm_hit, st_clr;
  logic [DATA_W-1:0] rmux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:MODE_USED];

  assign mode_wr = wr_i & (addr_i == REG_MODE);
  assign restart = mode_wr & wdata_i[MODE_RESTART];
  assign div_chg = mode_wr & (wdata_i[PRESC_W-1:0] != mode_q.div);
  assign st_clr  = rd_i & (addr_i == REG_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '{inc_en: 1'b0, alm_en: 1'b0, div: RESET_DIV};
      alarm_q <= '1;
    end else if (wr_i) begin
      if (addr_i == REG_MODE)
        mode_q <= '{inc_en: wdata_i[MODE_INC_EN], alm_en: wdata_i[MODE_ALM_EN],
                    div: wdata_i[PRESC_W-1:0]};
      if (addr_i == REG_ALARM) alarm_q <= wdata_i;
    end
  end

  rtt_prescaler #(.W(PRESC_W)) u_presc (
    .clk_i, .rst_ni, .tick_i,
    .restart_i (restart | div_chg),
    .div_i     (mode_q.div),
    .wrap_o    (wrap)
  );

  rtt_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .restart_i   (restart),
    .inc_i       (wrap),
    .alarm_i     (alarm_q),
    .cnt_o       (cnt),
    .alarm_hit_o (alm_hit)
  );

  rtt_status u_stat (
    .clk_i, .rst_ni,
    .alm_ev_i (alm_hit),
    .inc_ev_i (wrap & ~restart),
    .clr_i    (st_clr),
    .en_i     ({mode_q.inc_en, mode_q.alm_en}),
    .flags_o  (flags),
    .irq_o    (irq_o)
  );

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      REG_MODE:   rmux[MODE_INC_EN:0] = {mode_q.inc_en, mode_q.alm_en, mode_q.div};
      REG_ALARM:  rmux = alarm_q;
      REG_COUNT:  rmux = cnt;
      REG_STATUS: rmux[1:0] = flags;
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rmux;
  end

  a_r1_count_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_COUNT && !wrap) |=> $stable(cnt));
  a_r2_restart_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_MODE) |=> !rdata_o[MODE_RESTART]);
  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.inc_en && !mode_q.alm_en) |-> !irq_o);
endmodule

// File: tb/tb_rtt_seconds_timer.sv
module tb_rtt_seconds_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, wr, rd;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  always #2 clk = ~clk;

  rtt_seconds_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [15:0] m_div = 16'h8000, m_pre = '0;
  logic        m_alen = 0, m_inen = 0, m_alf = 0, m_inf = 0;
  logic [31:0] m_cnt = '0, m_alarm = '1, m_rdata = '0;

  function automatic logic m_irq();
    return (m_alf & m_alen) | (m_inf & m_inen);
  endfunction

  function automatic string tag_for(logic [1:0] a);
    case (a)
      2'd0: return "R2 mode readback";
      2'd1: return "R5 alarm readback";
      2'd2: return "R3 counter";
      default: return "R8 status";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_step(logic w, logic r, logic [1:0] a, logic [31:0] d, logic t);
    logic        rst_c, chg, inc, aev, clr;
    logic [16:0] lim;
    rst_c = w && a == 2'd0 && d[18];
    chg   = w && a == 2'd0 && d[15:0] != m_div;
    lim   = (m_div == 16'd0) ? 17'h10000 : {1'b0, m_div};
    inc   = t && !(rst_c || chg) && ({1'b0, m_pre} == lim - 17'd1);
    aev   = inc && m_cnt == m_alarm && m_alarm != 32'hFFFF_FFFF;
    clr   = r && a == 2'd3;
    if (r) begin
      case (a)
        2'd0: m_rdata = {14'd0, m_inen, m_alen, m_div};
        2'd1: m_rdata = m_alarm;
        2'd2: m_rdata = m_cnt;
        default: m_rdata = {30'd0, m_inf, m_alf};
      endcase
    end
    m_alf = (m_alf && !clr) || aev;
    m_inf = (m_inf && !clr) || inc;
    if (rst_c || chg) m_pre = '0;
    else if (t)       m_pre = inc ? 16'd0 : m_pre + 16'd1;
    if (rst_c)        m_cnt = '0;
    else if (inc)     m_cnt = m_cnt + 32'd1;
    if (w && a == 2'd0) begin m_div = d[15:0]; m_alen = d[16]; m_inen = d[17]; end
    if (w && a == 2'd1) m_alarm = d;
  endfunction

  task automatic cyc(logic w, logic r, logic [1:0] a, logic [31:0] d, logic t);
    wr = w; rd = r; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_step(w, r, a, d, t);
    @(negedge clk);
    wr = 0; rd = 0; tick = 0;
    check("R10 irq", {31'd0, irq}, {31'd0, m_irq()});
    if (r) check(tag_for(a), rdata, m_rdata);
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d); cyc(1, 0, a, d, 0); endtask
  task automatic rreg(logic [1:0] a);                 cyc(0, 1, a, 0, 0); endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tick = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    rreg(0); check("R11 mode reset", rdata, 32'h0000_8000);
    rreg(1); check("R5 alarm reset", rdata, 32'hFFFF_FFFF);
    rreg(2); check("R11 counter reset", rdata, 32'd0);
    rreg(3); check("R11 status reset", rdata, 32'd0);

    // R2 restart, bit reads 0; R4 division change restarts phase
    wreg(0, 32'h0004_0003);
    rreg(0); check("R2 restart bit reads 0", rdata, 32'h0000_0003);
    ticks(2);
    wreg(0, 32'h0000_0002);
    ticks(1);
    rreg(2); check("R4 phase restarted", rdata, 32'd0);
    ticks(1);
    rreg(2); check("R4 step after new phase", rdata, 32'd1);
    wreg(0, 32'h0000_0002);  // same value: phase kept
    ticks(1);
    rreg(2); check("R4 same div keeps phase", rdata, 32'd1);
    ticks(1);
    rreg(2); check("R4 step after kept phase", rdata, 32'd2);

    // R1 counter write ignored
    wreg(2, 32'h1234_5678);
    rreg(2); check("R1 counter write ignored", rdata, 32'd2);

    // R6 alarm at value+1, R7 increment flag
    wreg(0, 32'h0005_0001);
    wreg(1, 32'd5);
    rreg(3);
    ticks(5);
    rreg(3); check("R7 inc flag without alarm", rdata, 32'h2);
    ticks(1);
    check("R6 irq on alarm", {31'd0, irq}, 32'd1);
    rreg(3); check("R6 alarm flag set", rdata, 32'h3);
    rreg(3); check("R8 status cleared", rdata, 32'h0);

    // R9 step coincides with status read
    wreg(0, 32'h0002_0001);
    cyc(0, 1, 2'd3, 0, 1); check("R9 read returns pre-event flags", rdata, 32'h0);
    check("R9 irq stays", {31'd0, irq}, 32'd1);
    rreg(3); check("R9 flag survived read", rdata, 32'h2);

    // R10 enable cleared keeps flag
    ticks(1);
    wreg(0, 32'h0000_0001);
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    rreg(3); check("R10 flag kept under mask", rdata, 32'h2);

    // R3 division 0 = 65536 ticks
    wreg(0, 32'h0004_0000);
    ticks(65535);
    rreg(2); check("R3 no step before 65536", rdata, 32'd0);
    ticks(1);
    rreg(2); check("R3 step at 65536", rdata, 32'd1);

    // random traffic
    wreg(0, 32'h0007_0002);
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic t;
      op = $urandom_range(0, 11);
      t  = $urandom_range(0, 1) == 1;
      case (op)
        0: cyc(1, 0, 2'd0,
               {13'd0, $urandom_range(0, 15) == 0, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 16'($urandom_range(1, 4))}, t);
        1: cyc(1, 0, 2'd1, m_cnt + 32'($urandom_range(0, 3)), t);
        2: cyc(1, 0, 2'd2, $urandom, t);
        3, 4, 5: cyc(0, 1, 2'($urandom_range(0, 3)), 0, t);
        6: cyc(1, 0, 2'd1, 32'hFFFF_FFFF, t);
        default: cyc(0, 0, 0, 0, t);
      endcase
    end

    summary();
    $finish;
  end
endmodule